// File: doc/BRIEF.md
# Byte-Lane Dual-Clock Pipelined Word Memory

This block is a storage array shared by two fully independent synchronous ports, A and B. Each port has its own clock and reset, and either port can reach any word at any time. A word is made of `LANES` lanes of `LANE_W` bits. The defaults give two 9-bit lanes, 18 bits in all. Every control, address and data input is captured on the port's rising clock edge. A read returns its data one clock after the captured cycle. Writes store only the lanes that are enabled.

Each port has two select inputs of opposite polarity, an active-low write strobe, an active-low enable per lane and an asynchronous active-low output enable. The output is a data bus with one valid flag per lane instead of tri-state pins: a lane that is not driven shows valid low and data zero. After a port has been deselected, output drive comes back only on the second consecutive selected cycle. The depth is a parameter and must be a power of two.

Top module: `dpr_bytewise_ram`

## Requirements
- R1: A port is selected only when `x_cs_n` is 0 and `x_cs` is 1. In a cycle with any other combination, no lane of that port is written and no lane is driven as a result of that cycle.
- R2: Lane k occupies word bits `k*LANE_W` to `k*LANE_W+LANE_W-1`, so bits 8:0 form the lower lane and bits 17:9 the upper lane. Lane k is enabled by `x_lane_n[k]` = 0.
- R3: A selected cycle with `x_wr_n` = 0 stores only the enabled lanes of `x_wdata`. Disabled lanes keep their previous contents.
- R4: A selected cycle with `x_wr_n` = 1 is a read. After the next rising edge, it drives `x_rvalid[k]` = 1 and the stored lane for each lane k that was enabled in the captured cycle. Lanes that were not enabled show valid 0 and data 0.
- R5: While `x_oe_n` is 1, all lanes of that port show valid 0 and data 0, with no clock edge needed. When `x_oe_n` returns to 0, the pipelined read result reappears.
- R6: A write cycle produces no read drive on any lane in the following output cycle.
- R7: A read drives its outputs only if the port was also selected in the cycle just before the read. The first selected cycle after a deselected cycle, or after reset, drives nothing.
- R8: Repeated reads of the same address, with no write to it in between, return the same value on every cycle.
- R9: A read on one port sees a write made by the other port in any earlier cycle. A read captured in the same cycle as the write returns the old contents.
- R10: While reset is asserted, and right after it, all valid flags and data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A write strobe, 0 = write, 1 = read |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_lane_n | input | LANES | Port A per-lane enables, active low |
| a_addr | input | $clog2(DEPTH) | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_rdata | output | LANES*LANE_W | Port A read data, 0 in lanes not driven |
| a_rvalid | output | LANES | Port A per-lane drive flags |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B write strobe, 0 = write, 1 = read |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_lane_n | input | LANES | Port B per-lane enables, active low |
| b_addr | input | $clog2(DEPTH) | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_rdata | output | LANES*LANE_W | Port B read data, 0 in lanes not driven |
| b_rvalid | output | LANES | Port B per-lane drive flags |

## Verification
A write on one port and a read of the same word on the other port can fall in the same cycle. The bench provokes this on purpose: one port writes a word while the other reads it in that cycle and in the cycles that follow. The bench's reference expects the old contents for the same-cycle read and the new contents for every later read. The random phase confines addresses to a small window so that such collisions happen often. It keeps only the two ports' writes to one word in the same cycle apart.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } port_op_e;

   // A port takes part in a cycle only for this select combination
   function automatic logic port_selected(input logic cs_n, input logic cs);
      return (!cs_n) && cs;
   endfunction

endpackage

// File: rtl/dpr_xor_lane.sv
// One lane of storage, shared by two clocks. Each port owns one bank, so no
// bank has two writers. The stored value is the XOR of both banks.
module dpr_xor_lane #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk_a,
   input  logic              wa_en,
   input  logic [AW-1:0]     a_addr,
   input  logic [LANE_W-1:0] a_din,
   output logic [LANE_W-1:0] a_rd,
   input  logic              clk_b,
   input  logic              wb_en,
   input  logic [AW-1:0]     b_addr,
   input  logic [LANE_W-1:0] b_din,
   output logic [LANE_W-1:0] b_rd
);

   logic [LANE_W-1:0] bank_a [DEPTH];
   logic [LANE_W-1:0] bank_b [DEPTH];

   always_ff @(posedge clk_a) begin
      if (wa_en) bank_a[a_addr] <= a_din ^ bank_b[a_addr];
   end

   always_ff @(posedge clk_b) begin
      if (wb_en) bank_b[b_addr] <= b_din ^ bank_a[b_addr];
   end

   assign a_rd = bank_a[a_addr] ^ bank_b[a_addr];
   assign b_rd = bank_a[b_addr] ^ bank_b[b_addr];

endmodule

// File: rtl/dpr_port_pipe.sv
// Input capture, warm-up tracking and the output register stage of one port.
module dpr_port_pipe
   import dpr_pkg::*;
#(
   parameter int unsigned AW     = 8,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned LANES  = 2,
   localparam int unsigned WW    = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             cs,
   input  logic             wr_n,
   input  logic             oe_n,
   input  logic [LANES-1:0] lane_n,
   input  logic [AW-1:0]    addr,
   input  logic [WW-1:0]    wdata,
   input  logic [WW-1:0]    rd_word,
   output logic [AW-1:0]    stg_addr,
   output logic [WW-1:0]    stg_wdata,
   output logic [LANES-1:0] wr_lane,
   output logic [WW-1:0]    rdata,
   output logic [LANES-1:0] rvalid
);

   logic             sel_in;
   logic             prev_sel;
   logic             s_warm;
   port_op_e         s_op;
   logic [LANES-1:0] s_lane_n;
   logic [LANES-1:0] rd_lane;
   logic [LANES-1:0] q_drv;
   logic [LANE_W-1:0] q_data [LANES];

   assign sel_in = port_selected(cs_n, cs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_sel  <= 1'b0;
         s_warm    <= 1'b0;
         s_op      <= OP_IDLE;
         s_lane_n  <= '1;
         stg_addr  <= '0;
         stg_wdata <= '0;
      end else begin
         prev_sel  <= sel_in;
         s_warm    <= prev_sel;
         s_op      <= !sel_in ? OP_IDLE : (wr_n ? OP_READ : OP_WRITE);
         s_lane_n  <= lane_n;
         stg_addr  <= addr;
         stg_wdata <= wdata;
      end
   end

   assign wr_lane = (s_op == OP_WRITE) ? ~s_lane_n : '0;
   assign rd_lane = (s_op == OP_READ && s_warm) ? ~s_lane_n : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_drv <= '0;
      else        q_drv <= rd_lane;
   end

   assign rvalid = q_drv & {LANES{~oe_n}};

   for (genvar i = 0; i < LANES; i++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q_data[i] <= '0;
         else if (rd_lane[i]) q_data[i] <= rd_word[i*LANE_W +: LANE_W];
      end
      assign rdata[i*LANE_W +: LANE_W] = rvalid[i] ? q_data[i] : '0;

      assert_lane_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lane_n[i] |=> ##1 !q_drv[i]);
   end

   assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_in |=> ##1 (q_drv == '0));

   assert_warmup_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_in |=> ##2 (q_drv == '0));

   assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_in && !wr_n) |=> ##1 (q_drv == '0));

endmodule

// File: rtl/dpr_bytewise_ram.sv
module dpr_bytewise_ram #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned LANES  = 2,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned WW    = LANE_W * LANES
) (
   input  logic             clk_a,
   input  logic             rst_a_n,
   input  logic             a_cs_n,
   input  logic             a_cs,
   input  logic             a_wr_n,
   input  logic             a_oe_n,
   input  logic [LANES-1:0] a_lane_n,
   input  logic [AW-1:0]    a_addr,
   input  logic [WW-1:0]    a_wdata,
   output logic [WW-1:0]    a_rdata,
   output logic [LANES-1:0] a_rvalid,
   input  logic             clk_b,
   input  logic             rst_b_n,
   input  logic             b_cs_n,
   input  logic             b_cs,
   input  logic             b_wr_n,
   input  logic             b_oe_n,
   input  logic [LANES-1:0] b_lane_n,
   input  logic [AW-1:0]    b_addr,
   input  logic [WW-1:0]    b_wdata,
   output logic [WW-1:0]    b_rdata,
   output logic [LANES-1:0] b_rvalid
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two, at least 2");
      assert (LANE_W >= 1 && LANES >= 1)
         else $fatal(1, "LANE_W and LANES must be at least 1");
   end

   logic [AW-1:0]    stg_addr_a, stg_addr_b;
   logic [WW-1:0]    stg_wdata_a, stg_wdata_b;
   logic [LANES-1:0] wr_lane_a, wr_lane_b;
   logic [WW-1:0]    rd_word_a, rd_word_b;

   dpr_port_pipe #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_port_a (
      .clk(clk_a), .rst_n(rst_a_n), .cs_n(a_cs_n), .cs(a_cs), .wr_n(a_wr_n),
      .oe_n(a_oe_n), .lane_n(a_lane_n), .addr(a_addr), .wdata(a_wdata),
      .rd_word(rd_word_a), .stg_addr(stg_addr_a), .stg_wdata(stg_wdata_a),
      .wr_lane(wr_lane_a), .rdata(a_rdata), .rvalid(a_rvalid)
   );

   dpr_port_pipe #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_port_b (
      .clk(clk_b), .rst_n(rst_b_n), .cs_n(b_cs_n), .cs(b_cs), .wr_n(b_wr_n),
      .oe_n(b_oe_n), .lane_n(b_lane_n), .addr(b_addr), .wdata(b_wdata),
      .rd_word(rd_word_b), .stg_addr(stg_addr_b), .stg_wdata(stg_wdata_b),
      .wr_lane(wr_lane_b), .rdata(b_rdata), .rvalid(b_rvalid)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      dpr_xor_lane #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_lane (
         .clk_a(clk_a), .wa_en(wr_lane_a[i]), .a_addr(stg_addr_a),
         .a_din(stg_wdata_a[i*LANE_W +: LANE_W]), .a_rd(rd_word_a[i*LANE_W +: LANE_W]),
         .clk_b(clk_b), .wb_en(wr_lane_b[i]), .b_addr(stg_addr_b),
         .b_din(stg_wdata_b[i*LANE_W +: LANE_W]), .b_rd(rd_word_b[i*LANE_W +: LANE_W])
      );
   end

endmodule

// File: tb/dpr_bytewise_ram_test.sv
`timescale 1ns/1ps
module dpr_bytewise_ram_test;

   localparam int DEPTH = 64;
   localparam int LW    = 9;
   localparam int NL    = 2;
   localparam int AW    = 6;
   localparam int WW    = LW * NL;

   typedef struct packed {
      logic          cs_n;
      logic          cs;
      logic          wr_n;
      logic          oe_n;
      logic [NL-1:0] ln_n;
      logic [AW-1:0] ad;
      logic [WW-1:0] wd;
   } op_t;

   typedef struct packed {
      logic [NL-1:0] drv;
      logic [WW-1:0] data;
      logic [3:0]    tag;
   } exp_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          cs_n [2];
   logic          cs   [2];
   logic          wr_n [2];
   logic          oe_n [2];
   logic [NL-1:0] ln_n [2];
   logic [AW-1:0] ad   [2];
   logic [WW-1:0] wd   [2];
   logic [WW-1:0] rdq  [2];
   logic [NL-1:0] rvl  [2];

   dpr_bytewise_ram #(.DEPTH(DEPTH), .LANE_W(LW), .LANES(NL)) uut (
      .clk_a(clk), .rst_a_n(rst_n), .a_cs_n(cs_n[0]), .a_cs(cs[0]), .a_wr_n(wr_n[0]),
      .a_oe_n(oe_n[0]), .a_lane_n(ln_n[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
      .a_rdata(rdq[0]), .a_rvalid(rvl[0]),
      .clk_b(clk), .rst_b_n(rst_n), .b_cs_n(cs_n[1]), .b_cs(cs[1]), .b_wr_n(wr_n[1]),
      .b_oe_n(oe_n[1]), .b_lane_n(ln_n[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
      .b_rdata(rdq[1]), .b_rvalid(rvl[1])
   );

   int n_tests = 0;
   int n_fail  = 0;
   int phase_tag = 0;
   logic          done = 1'b0;
   logic [WW-1:0] mdl [16];
   logic          prev_sel [2];
   exp_t          d1 [2];
   exp_t          d2 [2];

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";   2: return "R2";  3: return "R3";  4: return "R4";
         5: return "R5";   6: return "R6";  7: return "R7";  8: return "R8";
         9: return "R9";  10: return "R10";
         default: return "R?";
      endcase
   endfunction

   function automatic op_t idle_op();
      op_t o;
      o = '0; o.cs_n = 1'b1; o.wr_n = 1'b1; o.ln_n = '1;
      return o;
   endfunction

   function automatic op_t mk(input logic wr, input int adr, input logic [WW-1:0] d,
                              input logic [NL-1:0] lanes_n, input logic oe);
      op_t o;
      o.cs_n = 1'b0; o.cs = 1'b1; o.wr_n = ~wr; o.oe_n = oe;
      o.ln_n = lanes_n; o.ad = AW'(adr); o.wd = d;
      return o;
   endfunction

   function automatic logic [WW-1:0] init_val(input int a);
      return WW'(32'h1_5A3C ^ (a * 32'h0_4F1B));
   endfunction

   task automatic check(input int tag, input string what, input logic [WW-1:0] act,
                        input logic [WW-1:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag_name(tag), what, act, expv);
      end
   endtask

   task automatic check_port(input int p);
      logic [NL-1:0] ev;
      logic [WW-1:0] ed;
      int t;
      ev = d2[p].drv & {NL{~oe_n[p]}};
      ed = '0;
      for (int i = 0; i < NL; i++)
         if (ev[i]) ed[i*LW +: LW] = d2[p].data[i*LW +: LW];
      t = d2[p].tag;
      if (t == 4 && oe_n[p]) t = 5;
      check(t, p == 0 ? "A valid" : "B valid", WW'(rvl[p]), WW'(ev));
      check(t, p == 0 ? "A data" : "B data", rdq[p], ed);
   endtask

   task automatic step(input op_t oa, input op_t ob);
      op_t  o [2];
      exp_t e;
      logic sel;
      o[0] = oa; o[1] = ob;
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         cs_n[p] = o[p].cs_n; cs[p] = o[p].cs; wr_n[p] = o[p].wr_n;
         oe_n[p] = o[p].oe_n; ln_n[p] = o[p].ln_n; ad[p] = o[p].ad; wd[p] = o[p].wd;
      end
      #1;
      for (int p = 0; p < 2; p++) check_port(p);
      for (int p = 0; p < 2; p++) begin
         sel = !o[p].cs_n && o[p].cs;
         e.drv  = (sel && o[p].wr_n && prev_sel[p]) ? ~o[p].ln_n : '0;
         e.data = mdl[o[p].ad[3:0]];
         if (phase_tag != 0)    e.tag = 4'(phase_tag);
         else if (!sel)         e.tag = 4'd1;
         else if (!o[p].wr_n)   e.tag = 4'd6;
         else if (!prev_sel[p]) e.tag = 4'd7;
         else                   e.tag = 4'd4;
         prev_sel[p] = sel;
         d2[p] = d1[p];
         d1[p] = e;
      end
      for (int p = 0; p < 2; p++) begin
         sel = !o[p].cs_n && o[p].cs;
         if (sel && !o[p].wr_n)
            for (int i = 0; i < NL; i++)
               if (!o[p].ln_n[i]) mdl[o[p].ad[3:0]][i*LW +: LW] = o[p].wd[i*LW +: LW];
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      op_t oa, ob;
      void'($urandom(32'd20517));
      rst_n = 1'b0;
      for (int p = 0; p < 2; p++) begin
         cs_n[p] = 1'b1; cs[p] = 1'b0; wr_n[p] = 1'b1; oe_n[p] = 1'b0;
         ln_n[p] = '1; ad[p] = '0; wd[p] = '0;
         prev_sel[p] = 1'b0;
         d1[p] = '{drv: '0, data: '0, tag: 4'd10};
         d2[p] = '{drv: '0, data: '0, tag: 4'd10};
      end
      for (int a = 0; a < 16; a++) mdl[a] = '0;
      repeat (3) @(negedge clk);
      // R10: outputs quiet while reset is held
      for (int p = 0; p < 2; p++) begin
         check(10, "reset valid", WW'(rvl[p]), '0);
         check(10, "reset data", rdq[p], '0);
      end
      rst_n = 1'b1;

      // Fill the window through port A
      for (int a = 0; a < 16; a++) step(mk(1, a, init_val(a), 2'b00, 0), idle_op());
      step(idle_op(), idle_op());

      // R3: lower-only write keeps the upper lane
      phase_tag = 3;
      step(mk(1, 2, 18'h2A_1C5, 2'b10, 0), idle_op());
      step(mk(0, 2, '0, 2'b00, 0), idle_op());
      step(mk(0, 2, '0, 2'b00, 0), idle_op());
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      // R2: upper-lane bit placement, read with the lower lane masked
      phase_tag = 2;
      step(idle_op(), mk(1, 3, 18'h3FE00, 2'b01, 0));
      step(idle_op(), mk(0, 3, '0, 2'b01, 0));
      step(idle_op(), mk(0, 3, '0, 2'b00, 0));
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      // R8: held address gives a constant result
      phase_tag = 8;
      repeat (6) step(mk(0, 5, '0, 2'b00, 0), idle_op());
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      // R9: write on A, same-cycle and later reads on B
      phase_tag = 9;
      step(idle_op(), mk(0, 7, '0, 2'b00, 0));
      step(mk(1, 7, 18'h0_7E31, 2'b00, 0), mk(0, 7, '0, 2'b00, 0));
      step(idle_op(), mk(0, 7, '0, 2'b00, 0));
      step(idle_op(), mk(0, 7, '0, 2'b00, 0));
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      // R7: single read after a deselected cycle drives nothing
      phase_tag = 0;
      step(mk(0, 1, '0, 2'b00, 0), idle_op());
      step(idle_op(), idle_op());
      step(mk(0, 1, '0, 2'b00, 0), idle_op());
      step(mk(0, 1, '0, 2'b00, 0), idle_op());
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      // R5: output enable toggled under a stream of reads
      for (int k = 0; k < 6; k++) step(mk(0, 4, '0, 2'b00, k[0]), idle_op());
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      // R1: both wrong select combinations block a write
      phase_tag = 1;
      oa = mk(1, 6, 18'h1_2345, 2'b00, 0); oa.cs_n = 1'b0; oa.cs = 1'b0;
      step(oa, idle_op());
      oa.cs_n = 1'b1; oa.cs = 1'b1;
      step(oa, idle_op());
      step(mk(0, 6, '0, 2'b00, 0), idle_op());
      step(mk(0, 6, '0, 2'b00, 0), idle_op());
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      // Random traffic on both ports
      phase_tag = 0;
      for (int n = 0; n < 3000; n++) begin
         oa = mk(($urandom % 3) == 0, $urandom % 16, WW'($urandom), NL'($urandom),
                 ($urandom % 8) == 0);
         ob = mk(($urandom % 3) == 0, $urandom % 16, WW'($urandom), NL'($urandom),
                 ($urandom % 8) == 0);
         if (($urandom % 8) == 0) oa.cs_n = 1'b1;
         if (($urandom % 8) == 0) ob.cs = 1'b0;
         if (!oa.wr_n && !ob.wr_n && oa.ad == ob.ad) ob.ad[0] = ~ob.ad[0];
         step(oa, ob);
      end
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());
      step(idle_op(), idle_op());

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule